// File: doc/BRIEF.md
# Data-Space Access Router with Local 1 kB Window

This block sits between a CPU's data-space bus and two targets: a 1 kB on-die SRAM and an external memory port. Every read or write strobe from the CPU is decoded against the local window. A hit is served from the local SRAM and completes in a single clock. Everything else is passed to the external port, which raises a request and waits for an acknowledge. The CPU sees a single `done` pulse in either case.

A two-bit enable field is written by software. At reset it is `00`, and in that state the local SRAM is switched off, so every access goes out on the external port. Any non-zero value opens the window at `0000h`–`03FFh`. Addresses at `0400h` and above go to the external port whatever the enable field holds.

Strobes are one-cycle pulses. Only one external access can be outstanding. A strobe that arrives while an external access is still pending is dropped.

Top module: `xdata_router`

## Requirements
- R1: After reset, `en_q` reads `00`, `cpu_done` is 0 and `ext_req` is 0.
- R2: A pulse on `cfg_we` loads `cfg_wdata` into the enable field. The new value is visible on `en_q` one cycle later.
- R3: While the enable field is `00`, every access goes to the external port, including addresses `0000h`–`03FFh`. `ext_req` rises one cycle after the strobe, and no `cpu_done` is given in that cycle.
- R4: While the enable field is non-zero, an access to `0000h`–`03FFh` is local. `cpu_done` is high in the cycle after the strobe, and `ext_req` stays 0.
- R5: A local write followed by a local read of the same address returns the written byte on `cpu_rdata` together with `cpu_done`.
- R6: While the enable field is non-zero, an access to `0400h`–`FFFFh` goes to the external port. `ext_addr` carries the full 16-bit address, and `ext_we` is 1 for a write and 0 for a read. For a write, `ext_wdata` carries the data.
- R7: `ext_req` stays high, with `ext_addr` unchanged, until `ext_ack` is sampled high. In the next cycle `ext_req` is 0 and `cpu_done` is 1. For a read, `cpu_rdata` then holds the `ext_rdata` value that was present with the acknowledge.
- R8: A write to `0000h`–`03FFh` while the enable field is `00` leaves the local SRAM unchanged.
- R9: While an external access is pending, new CPU strobes are ignored. `ext_addr` does not change, and only one `cpu_done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Enable field write strobe |
| cfg_wdata | input | 2 | New enable field value |
| en_q | output | 2 | Current enable field |
| cpu_addr | input | 16 | Access address |
| cpu_rd | input | 1 | Read strobe (one-cycle pulse) |
| cpu_wr | input | 1 | Write strobe (one-cycle pulse) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | Access completion pulse |
| ext_req | output | 1 | External access request |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | 16 | External access address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, sampled with `ext_ack` |
| ext_ack | input | 1 | External access acknowledge |

## Verification
The hardest case to reach from the ports is a write to the window that is ignored while the window is disabled. The local SRAM cannot be read while the window is off, so the bench has to close and reopen the window around that write. First it writes a known byte with the window open. Then it turns the window off and writes a different byte to the same address, which must leave through the external port. Finally it reopens the window and reads the address back, expecting the first byte. Strobes that are dropped during a pending external access are exposed in a similar way. Extra pulses are sent while the acknowledge is held back, and the bench then confirms that the address is stable and that only one completion arrives.

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int LOCAL_AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_wdata,
  output logic [1:0]    en_q,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_done,
  output logic          ext_req,
  output logic          ext_we,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_wdata,
  input  logic [DW-1:0] ext_rdata,
  input  logic          ext_ack
);
  localparam int LOCAL_DEPTH = 1 << LOCAL_AW;

  logic [DW-1:0] ram [LOCAL_DEPTH];

  wire start     = (cpu_rd | cpu_wr) & ~ext_req;
  wire in_window = (cpu_addr[AW-1:LOCAL_AW] == '0);
  wire local_hit = start & (en_q != 2'b00) & in_window;
  wire go_ext    = start & ~local_hit;
  wire [LOCAL_AW-1:0] idx = cpu_addr[LOCAL_AW-1:0];

  always_ff @(posedge clk)
    if (local_hit && cpu_wr) ram[idx] <= cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 2'b00;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      ext_req   <= 1'b0;
      ext_we    <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
    end else begin
      if (cfg_we) en_q <= cfg_wdata;
      cpu_done <= local_hit | (ext_req & ext_ack);
      if (local_hit && !cpu_wr) cpu_rdata <= ram[idx];
      if (ext_req && ext_ack) begin
        ext_req <= 1'b0;
        if (!ext_we) cpu_rdata <= ext_rdata;
      end
      if (go_ext) begin
        ext_req   <= 1'b1;
        ext_we    <= cpu_wr;
        ext_addr  <= cpu_addr;
        ext_wdata <= cpu_wdata;
      end
    end
  end

  // R3
  off_goes_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && en_q == 2'b00) |=> (ext_req && !cpu_done));
  // R4
  local_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && en_q != 2'b00 && cpu_addr < AW'(LOCAL_DEPTH)) |=> (cpu_done && !ext_req));
  // R6
  high_addr_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cpu_addr >= AW'(LOCAL_DEPTH)) |=> (ext_req && ext_addr == $past(cpu_addr)));
  // R7
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && !cpu_done));
  // R7
  ext_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack) |=> (cpu_done && !ext_req));
  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q == $past(cfg_wdata)));
endmodule

// File: tb/xdata_router_tb.sv
module xdata_router_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_wdata = 0; logic [1:0] en_q;
  logic [15:0] cpu_addr = 0; logic cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic cpu_done, ext_req, ext_we; logic [15:0] ext_addr; logic [7:0] ext_wdata;
  logic [7:0] ext_rdata = 0; logic ext_ack = 0;

  int total = 0, bad = 0;
  logic g_local; logic [7:0] g_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  xdata_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .en_q(en_q),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .ext_req(ext_req), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack));

  typedef struct packed {
    logic [1:0]  cfg;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        is_local;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{2'd0, 1'b1, 16'h0010, 8'h11, 1'b0, 8'h00},
    '{2'd1, 1'b1, 16'h0010, 8'h22, 1'b1, 8'h00},
    '{2'd1, 1'b0, 16'h0010, 8'h00, 1'b1, 8'h22},
    '{2'd2, 1'b1, 16'h03FF, 8'h33, 1'b1, 8'h00},
    '{2'd3, 1'b0, 16'h03FF, 8'h00, 1'b1, 8'h33},
    '{2'd3, 1'b0, 16'h0400, 8'h00, 1'b0, 8'h5A},
    '{2'd1, 1'b1, 16'hFFFF, 8'h44, 1'b0, 8'h00},
    '{2'd0, 1'b0, 16'h0010, 8'h00, 1'b0, 8'h4A},
    '{2'd0, 1'b1, 16'h0010, 8'h55, 1'b0, 8'h00},
    '{2'd1, 1'b0, 16'h0010, 8'h00, 1'b1, 8'h22},
    '{2'd3, 1'b0, 16'h8000, 8'h00, 1'b0, 8'h5A}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d, input int lat);
    @(negedge clk); cpu_wr = wr; cpu_rd = !wr; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0; cpu_rd = 0;
    g_local = cpu_done && !ext_req;
    g_rd = cpu_rdata;
    if (!g_local) begin
      chk(ext_req && ext_addr == a && ext_we == wr, "R6", "ext request fields", {ext_req, ext_we, ext_addr}, {1'b1, wr, a});
      if (wr) chk(ext_wdata == d, "R6", "ext write data", ext_wdata, d);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(ext_req && !cpu_done && ext_addr == a, "R7", "hold without ack", {ext_req, cpu_done}, 2'b10);
      end
      ext_rdata = a[7:0] ^ 8'h5A; ext_ack = 1;
      @(negedge clk); ext_ack = 0; ext_rdata = 8'h00;
      chk(cpu_done && !ext_req, "R7", "done after ack", {cpu_done, ext_req}, 2'b10);
      g_rd = cpu_rdata;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(en_q == 2'b00, "R1", "enable after reset", en_q, 0);
    chk(!cpu_done && !ext_req, "R1", "idle after reset", {cpu_done, ext_req}, 0);
    // R2
    set_cfg(2'd2);
    chk(en_q == 2'd2, "R2", "enable readback", en_q, 2);
    set_cfg(2'd0);
    chk(en_q == 2'd0, "R2", "enable cleared", en_q, 0);

    for (int i = 0; i < 11; i++) begin
      vec_t v = TBL[i];
      string tag;
      if (v.cfg == 0) tag = "R3";
      else if (v.addr < 16'h0400) tag = "R4";
      else tag = "R6";
      set_cfg(v.cfg);
      access(v.wr, v.addr, v.data, i % 3);
      chk(g_local == v.is_local, tag, "routing", g_local, v.is_local);
      if (!v.wr) chk(g_rd == v.exp, v.is_local ? "R5" : "R7", "read data", g_rd, v.exp);
    end

    // R8: write to disabled window must not reach local SRAM
    set_cfg(2'd1);
    access(1'b1, 16'h0123, 8'h77, 0);
    set_cfg(2'd0);
    access(1'b1, 16'h0123, 8'h88, 1);
    chk(!g_local, "R8", "disabled write routed external", g_local, 0);
    set_cfg(2'd3);
    access(1'b0, 16'h0123, 8'h00, 0);
    chk(g_local && g_rd == 8'h77, "R8", "local byte preserved", g_rd, 8'h77);

    // R9: strobes during pending external access are dropped
    begin
      int dones = 0;
      @(negedge clk); cpu_rd = 1; cpu_addr = 16'h2000;
      @(negedge clk); cpu_rd = 0;
      chk(ext_req && ext_addr == 16'h2000, "R9", "ext started", ext_addr, 16'h2000);
      cpu_wr = 1; cpu_addr = 16'h0005; cpu_wdata = 8'hEE;
      @(negedge clk); cpu_wr = 0; cpu_rd = 1; cpu_addr = 16'h3000;
      if (cpu_done) dones++;
      @(negedge clk); cpu_rd = 0;
      if (cpu_done) dones++;
      chk(ext_addr == 16'h2000 && ext_req, "R9", "addr stable while pending", ext_addr, 16'h2000);
      ext_rdata = 8'h3C; ext_ack = 1;
      @(negedge clk); ext_ack = 0;
      if (cpu_done) dones++;
      chk(cpu_rdata == 8'h3C, "R7", "pending read data", cpu_rdata, 8'h3C);
      repeat (3) begin
        @(negedge clk);
        if (cpu_done) dones++;
        chk(!ext_req, "R9", "no late request", ext_req, 0);
      end
      chk(dones == 1, "R9", "single completion", dones, 1);
      access(1'b0, 16'h0005, 8'h00, 0);
      chk(g_local && g_rd != 8'hEE, "R9", "dropped write not stored", g_rd, 8'hEE);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule